// File: doc/BRIEF.md
# Flash Status Word with Read Overlay

This block is the status-reporting part of a parallel NOR-style flash device. It keeps an 8-bit status byte, and reads return it zero-extended to a 16-bit word. Five result flags in that byte are sticky. One-cycle pulses from the embedded program/erase engine set them. Three live flags follow the engine's busy and suspend signals, each one register behind them.

A decoded status-read command takes a snapshot of the status word and puts the block into an overlay mode. In that mode every read returns the snapshot, whatever the address and whatever the array data. The mode ends when a completed read finishes, that is, when chip-enable or output-enable rises after both were low. In byte-wide mode the low address bit picks one half of the word, so both halves can be read in one overlay session. Two further commands clear the result flags: a clear-status command and a soft reset. Each clears its own subset, and the soft reset acts only while the abort flag is zero.

All strobes arrive already synchronised to one clock. The reset is synchronous and active high.

Top module: `flash_status_overlay`

## Requirements
- R1: While `rst` is high, all flags are cleared, overlay mode is left and `rd_data` is 0 one cycle later.
- R2: The status word is laid out as {8'h00, busy, erase-suspended, erase-fail, program-fail, abort, program-suspended, sector-locked, continuity-pattern}, from bit 15 down to bit 0. The reserved bits 15:8 read as zero.
- R3: A high bit on `res_set` ([4] erase-fail, [3] program-fail, [2] abort, [1] sector-locked, [0] continuity) sets its flag on the next clock. The flag stays set until a clear command. If a set pulse and a clear act in the same cycle, the set wins.
- R4: A `cmd_we` with `cmd_code == SR_READ` (default 8'h70) while not in overlay mode does two things. It captures the current status word as the snapshot, and `sr_mode` is high after that clock.
- R5: In overlay mode, a read (`ce_n` and `oe_n` both low) returns the snapshot. Array data, address and later flag changes have no effect on the value returned.
- R6: Overlay mode ends on the clock at which `ce_n` or `oe_n` is high after a cycle with both low inside the mode. While no such read has happened, the mode persists.
- R7: Any `cmd_we` in overlay mode is ignored. This covers clear, soft reset and a repeated status read: no flag changes and the mode stays.
- R8: When `byte_mode` is high, a read in overlay mode returns bits 7:0 of the snapshot when `addr_lsb` is 0 and bits 15:8 when it is 1, each placed in `rd_data[7:0]` with `rd_data[15:8]` zero. Switching `addr_lsb` with both strobes low keeps the mode.
- R9: A soft reset (`cmd_code == SOFT_RST`, default 8'hF0) outside overlay mode clears bits 5, 4, 1 and 0 when bit 3 (abort) is zero. When abort is set it changes nothing. It never alters bits 7, 6 and 2.
- R10: A clear-status command (`cmd_code == CLR_SR`, default 8'h71) outside overlay mode clears bits 5, 4, 3, 1 and 0 and leaves bits 7, 6 and 2 unchanged.
- R11: Outside overlay mode, `rd_data` equals `array_data` one cycle after a cycle with `ce_n` and `oe_n` both low. After any other cycle it is 0.
- R12: Bits 7, 6 and 2 follow `state_in` ([2] busy, [1] erase-suspended, [0] program-suspended) with one register of delay. A status read issued in the same cycle as a change captures the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | One-cycle decoded command write strobe |
| cmd_code | input | 8 | Decoded command code |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_mode | input | 1 | Byte-wide read mode select |
| addr_lsb | input | 1 | Byte select within a word in byte mode |
| array_data | input | 16 | Data from the memory array for normal reads |
| res_set | input | 5 | Result flag set pulses from the algorithm engine |
| state_in | input | 3 | Live busy and suspend signals from the algorithm engine |
| rd_data | output | 16 | Registered read data |
| sr_mode | output | 1 | High while the status overlay is active |

## Verification
The assertions check on every cycle the parts of the behaviour that depend only on the cycle before:
- entry into the overlay after a status-read command;
- the mode persisting during an active read;
- zero reserved bits;
- byte-mode zero-extension;
- array pass-through outside the overlay;
- a zero bus when the strobes are idle.

Only the bench's scenarios can show that the snapshot is frozen against later flag changes, that commands are ignored during the overlay, and which subset each clear command takes, including the abort-gated soft reset. The same holds for set-over-clear priority and the one-cycle lag of the live bits. These require a history model across several commands.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  // Status byte, field order fixed by bit position (bit 7 first).
  typedef struct packed {
    logic busy;       // 7
    logic esusp;      // 6
    logic efail;      // 5
    logic pfail;      // 4
    logic abort;      // 3
    logic psusp;      // 2
    logic lock;       // 1
    logic cont;       // 0
  } fsr_word_t;

  localparam int unsigned NUM_RES = 5;
  localparam int unsigned NUM_LIVE = 3;

  // Index into the result vector
  localparam int unsigned RI_EFAIL = 4;
  localparam int unsigned RI_PFAIL = 3;
  localparam int unsigned RI_ABORT = 2;
  localparam int unsigned RI_LOCK  = 1;
  localparam int unsigned RI_CONT  = 0;

  // Which result flags each clear command touches
  localparam logic [NUM_RES-1:0] CLR_ALL_MASK  = 5'b11111;
  localparam logic [NUM_RES-1:0] CLR_SOFT_MASK = 5'b11011;

endpackage

// File: rtl/fsr_bits.sv
module fsr_bits
  import fsr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_all,
  input  logic                clr_soft,
  input  logic [NUM_RES-1:0]  res_set,
  input  logic [NUM_LIVE-1:0] state_in,
  output fsr_word_t           cur
);

  logic [NUM_RES-1:0]  res_q;
  logic [NUM_LIVE-1:0] live_q;
  logic [NUM_RES-1:0]  clr_mask;

  // Soft reset is gated by the abort flag as currently held
  always_comb begin
    clr_mask = '0;
    if (clr_all)
      clr_mask = CLR_ALL_MASK;
    else if (clr_soft && !res_q[RI_ABORT])
      clr_mask = CLR_SOFT_MASK;
  end

  // One sticky cell per result flag; set has priority over clear
  for (genvar i = 0; i < NUM_RES; i++) begin : g_res
    always_ff @(posedge clk) begin
      if (rst)
        res_q[i] <= 1'b0;
      else if (res_set[i])
        res_q[i] <= 1'b1;
      else if (clr_mask[i])
        res_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) live_q <= '0;
    else     live_q <= state_in;
  end

  always_comb begin
    cur.busy  = live_q[2];
    cur.esusp = live_q[1];
    cur.psusp = live_q[0];
    cur.efail = res_q[RI_EFAIL];
    cur.pfail = res_q[RI_PFAIL];
    cur.abort = res_q[RI_ABORT];
    cur.lock  = res_q[RI_LOCK];
    cur.cont  = res_q[RI_CONT];
  end

endmodule

// File: rtl/fsr_ovl.sv
module fsr_ovl
  import fsr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rd_cmd,
  input  logic      ce_n,
  input  logic      oe_n,
  input  fsr_word_t cur,
  output logic      mode,
  output fsr_word_t snap
);

  logic read_seen_q;
  logic rd_active;
  logic leave;

  assign rd_active = !ce_n && !oe_n;
  // A strobe high after a completed low phase marks the rising edge
  assign leave = mode && read_seen_q && (ce_n || oe_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode        <= 1'b0;
      read_seen_q <= 1'b0;
      snap        <= '0;
    end else if (mode) begin
      if (leave) begin
        mode        <= 1'b0;
        read_seen_q <= 1'b0;
      end else if (rd_active) begin
        read_seen_q <= 1'b1;
      end
    end else if (rd_cmd) begin
      mode        <= 1'b1;
      read_seen_q <= 1'b0;
      snap        <= cur;
    end
  end

endmodule

// File: rtl/fsr_rdmux.sv
module fsr_rdmux
  import fsr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  fsr_word_t         snap,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              byte_mode,
  input  logic              addr_lsb,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned PAD_W  = DATA_W - $bits(fsr_word_t);

  logic [DATA_W-1:0] snap_ext;
  logic [HALF_W-1:0] half_sel;
  logic [DATA_W-1:0] ovl_val;
  logic [DATA_W-1:0] next_val;

  assign snap_ext = {{PAD_W{1'b0}}, snap};
  assign half_sel = addr_lsb ? snap_ext[DATA_W-1:HALF_W] : snap_ext[HALF_W-1:0];
  assign ovl_val  = byte_mode ? {{HALF_W{1'b0}}, half_sel} : snap_ext;

  always_comb begin
    next_val = '0;
    if (!ce_n && !oe_n)
      next_val = mode ? ovl_val : array_data;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= next_val;
  end

endmodule

// File: rtl/flash_status_overlay.sv
module flash_status_overlay
  import fsr_pkg::*;
#(
  parameter int unsigned       DATA_W      = 16,
  parameter int unsigned       CMD_W       = 8,
  parameter logic [CMD_W-1:0]  SR_READ     = 8'h70,
  parameter logic [CMD_W-1:0]  CLR_SR      = 8'h71,
  parameter logic [CMD_W-1:0]  SOFT_RST    = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              byte_mode,
  input  logic              addr_lsb,
  input  logic [DATA_W-1:0] array_data,
  input  logic [4:0]        res_set,
  input  logic [2:0]        state_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              sr_mode
);

  fsr_word_t cur;
  fsr_word_t snap;
  logic      cmd_live;
  logic      do_read, do_clr, do_soft;

  // Commands only take effect outside the overlay
  assign cmd_live = cmd_we && !sr_mode;
  assign do_read  = cmd_live && (cmd_code == SR_READ);
  assign do_clr   = cmd_live && (cmd_code == CLR_SR);
  assign do_soft  = cmd_live && (cmd_code == SOFT_RST);

  fsr_bits u_bits (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (do_clr),
    .clr_soft (do_soft),
    .res_set  (res_set),
    .state_in (state_in),
    .cur      (cur)
  );

  fsr_ovl u_ovl (
    .clk    (clk),
    .rst    (rst),
    .rd_cmd (do_read),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .cur    (cur),
    .mode   (sr_mode),
    .snap   (snap)
  );

  fsr_rdmux #(.DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .mode       (sr_mode),
    .snap       (snap),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .byte_mode  (byte_mode),
    .addr_lsb   (addr_lsb),
    .array_data (array_data),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/fsr_chk.sv
module fsr_chk #(
  parameter int unsigned      DATA_W  = 16,
  parameter int unsigned      CMD_W   = 8,
  parameter logic [CMD_W-1:0] SR_READ = 8'h70
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_we,
  input logic [CMD_W-1:0]  cmd_code,
  input logic              ce_n,
  input logic              oe_n,
  input logic              byte_mode,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              sr_mode
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!sr_mode && rd_data == '0));

  // R4
  enter_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_code == SR_READ && !sr_mode) |=> sr_mode);

  // R6
  hold_during_read_chk: assert property (@(posedge clk) disable iff (rst)
    (sr_mode && !ce_n && !oe_n) |=> sr_mode);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sr_mode && !byte_mode) |=> rd_data[DATA_W-1:DATA_W/2] == '0);

  // R8
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sr_mode && byte_mode) |=> rd_data[DATA_W-1:DATA_W/2] == '0);

  // R11
  array_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!sr_mode && !ce_n && !oe_n) |=> rd_data == $past(array_data));

  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n) |=> rd_data == '0);

endmodule

bind flash_status_overlay fsr_chk #(
  .DATA_W(DATA_W), .CMD_W(CMD_W), .SR_READ(SR_READ)
) u_chk (
  .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_code(cmd_code),
  .ce_n(ce_n), .oe_n(oe_n), .byte_mode(byte_mode),
  .array_data(array_data), .rd_data(rd_data), .sr_mode(sr_mode)
);

// File: tb/flash_status_overlay_bench.sv
module flash_status_overlay_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic        ce_n = 1'b1, oe_n = 1'b1;
  logic        byte_mode = 1'b0, addr_lsb = 1'b0;
  logic [15:0] array_data = 16'h0;
  logic [4:0]  res_set = 5'h0;
  logic [2:0]  state_in = 3'h0;
  logic [15:0] rd_data;
  logic        sr_mode;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  flash_status_overlay u_flash_status_overlay (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .ce_n(ce_n), .oe_n(oe_n), .byte_mode(byte_mode), .addr_lsb(addr_lsb),
    .array_data(array_data), .res_set(res_set), .state_in(state_in),
    .rd_data(rd_data), .sr_mode(sr_mode)
  );

  // ---------------- behavioural reference ----------------
  logic [4:0]  m_res;    // {efail,pfail,abort,lock,cont}
  logic [2:0]  m_live;   // {busy,esusp,psusp}
  logic        m_mode, m_seen, m_ovl_word;
  logic [15:0] m_snap, m_rd;

  function automatic logic [15:0] word_of(logic [4:0] r, logic [2:0] l);
    return {8'h00, l[2], l[1], r[4], r[3], r[2], l[0], r[1], r[0]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_res = 0; m_live = 0; m_mode = 0; m_seen = 0;
      m_snap = 0; m_rd = 0; m_ovl_word = 0;
    end else begin
      logic [15:0] w;
      logic [4:0]  keep;
      w = word_of(m_res, m_live);
      m_ovl_word = 0;
      if (!ce_n && !oe_n) begin
        if (m_mode) begin
          if (byte_mode) m_rd = addr_lsb ? {8'h00, m_snap[15:8]} : {8'h00, m_snap[7:0]};
          else begin m_rd = m_snap; m_ovl_word = 1; end
        end else m_rd = array_data;
      end else m_rd = 0;
      keep = 5'b11111;
      if (!m_mode && cmd_we) begin
        if (cmd_code == 8'h71) keep = 5'b00000;
        else if (cmd_code == 8'hF0 && !m_res[2]) keep = 5'b00100;
      end
      if (m_mode) begin
        if (m_seen && (ce_n || oe_n)) begin m_mode = 0; m_seen = 0; end
        else if (!ce_n && !oe_n) m_seen = 1;
      end else if (cmd_we && cmd_code == 8'h70) begin
        m_snap = w; m_mode = 1; m_seen = 0;
      end
      m_res  = (m_res & keep) | res_set;
      m_live = state_in;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference (reserved bits masked on word overlay reads)
  always @(negedge clk) begin
    if (!rst) begin
      chk(sr_mode === m_mode, "R6 mode", {15'h0, sr_mode}, {15'h0, m_mode});
      if (m_ovl_word)
        chk(rd_data[7:0] === m_rd[7:0], "R5 overlay", rd_data, m_rd);
      else
        chk(rd_data === m_rd, m_mode ? "R8 overlay" : "R11 read", rd_data, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(); @(negedge clk); endtask

  task automatic cmd(input logic [7:0] c);
    cmd_we = 1; cmd_code = c; cyc(); cmd_we = 0;
  endtask

  task automatic pulse(input logic [4:0] p);
    res_set = p; cyc(); res_set = 0;
  endtask

  // Read one word in overlay; returns data, then releases strobes
  task automatic sr_read_word(output logic [15:0] v);
    cmd(8'h70);
    byte_mode = 0; ce_n = 0; oe_n = 0; cyc();
    v = rd_data;
    ce_n = 1; oe_n = 1; cyc();
  endtask

  initial begin : watchdog
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) cyc();
    rst = 0; cyc();
    chk(rd_data == 0 && sr_mode == 0, "R1 reset", rd_data, 16'h0);

    // R3, R12: flags and live state, R4 entry
    state_in = 3'b101;
    pulse(5'b10011);
    cmd(8'h70);
    chk(sr_mode == 1, "R4 entry", {15'h0, sr_mode}, 16'h1);
    state_in = 3'b010; res_set = 5'b01000; array_data = 16'hBEEF;
    ce_n = 0; oe_n = 0; cyc(); res_set = 0;
    chk(rd_data[7:0] == 8'hA7, "R5 snapshot", rd_data, 16'h00A7);
    chk(rd_data[15:8] == 8'h00, "R2 reserved", rd_data, 16'h00A7);
    cmd_we = 1; cmd_code = 8'h71; cyc(); cmd_we = 0;
    chk(sr_mode == 1, "R7 write ignored mode", {15'h0, sr_mode}, 16'h1);
    oe_n = 1; cyc();
    chk(sr_mode == 0, "R6 exit", {15'h0, sr_mode}, 16'h0);

    // R11 array read
    array_data = 16'h1234; oe_n = 0; cyc();
    chk(rd_data == 16'h1234, "R11 array", rd_data, 16'h1234);
    ce_n = 1; oe_n = 1; cyc();
    chk(rd_data == 16'h0, "R11 idle", rd_data, 16'h0);

    // R8 byte mode, both halves in one session; R7 clear was ignored
    cmd(8'h70);
    byte_mode = 1; addr_lsb = 0; ce_n = 0; oe_n = 0; cyc();
    chk(rd_data == 16'h0073, "R7 flags kept / R8 low byte", rd_data, 16'h0073);
    addr_lsb = 1; cyc();
    chk(rd_data == 16'h0000, "R8 high byte", rd_data, 16'h0000);
    chk(sr_mode == 1, "R8 session held", {15'h0, sr_mode}, 16'h1);
    ce_n = 1; oe_n = 1; byte_mode = 0; addr_lsb = 0; cyc();

    // R9 soft reset blocked by abort
    pulse(5'b00100);
    cmd(8'hF0);
    sr_read_word(v);
    chk(v[7:0] == 8'h7B, "R9 soft reset blocked", v, 16'h007B);

    // R10 clear status
    cmd(8'h71);
    sr_read_word(v);
    chk(v[7:0] == 8'h40, "R10 clear", v, 16'h0040);

    // R9 soft reset with abort zero
    pulse(5'b10001);
    cmd(8'hF0);
    sr_read_word(v);
    chk(v[7:0] == 8'h40, "R9 soft reset clears", v, 16'h0040);

    // R3 set wins over clear
    res_set = 5'b01000; cmd(8'h71); res_set = 0;
    sr_read_word(v);
    chk(v[7:0] == 8'h50, "R3 set beats clear", v, 16'h0050);

    // R12 state change in same cycle as status read is not captured
    state_in = 3'b100; cmd(8'h70);
    ce_n = 0; oe_n = 0; cyc();
    chk(rd_data[7:0] == 8'h50, "R12 lag", rd_data, 16'h0050);
    ce_n = 1; oe_n = 1; cyc();
    sr_read_word(v);
    chk(v[7:0] == 8'h90, "R12 follow", v, 16'h0090);

    // Random traffic compared by the reference every cycle
    for (int i = 0; i < 3000; i++) begin
      cmd_we     = ($urandom % 5) == 0;
      case ($urandom % 4)
        0: cmd_code = 8'h70;
        1: cmd_code = 8'h71;
        2: cmd_code = 8'hF0;
        default: cmd_code = 8'h55;
      endcase
      ce_n       = ($urandom % 3) == 0;
      oe_n       = ($urandom % 3) == 0;
      byte_mode  = $urandom % 2;
      addr_lsb   = $urandom % 2;
      array_data = 16'($urandom);
      res_set    = (($urandom % 4) == 0) ? 5'($urandom) : 5'h0;
      state_in   = 3'($urandom);
      cyc();
    end
    cmd_we = 0; ce_n = 1; oe_n = 1; cyc(); cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule